// File: doc/BRIEF.md
# Registered Signed Adder-Subtractor

This block adds or subtracts two two's-complement operands and raises a flag when the signed result does not fit. It has a register stage on each side of the arithmetic. The operands and the mode bit are captured together on one rising clock edge. The arithmetic between the two stages is a ripple chain of full-adder cells. The following edge captures the result and the overflow flag.

For subtraction, the second operand is inverted bit by bit and a carry of one is injected at the bottom of the chain. Addition and subtraction therefore share the same chain. An active-low asynchronous reset clears every register at once. A parameter selects how the overflow flag is derived. Either choice gives the same flag.

Top module: `sgn_addsub_reg`

## Requirements
- R1: The operands `a` and `b` and the result `s` are WIDTH bits wide (default 8) and are read as signed two's-complement numbers.
- R2: Values on `a`, `b` and `sub` sampled at one rising edge produce `s` and `overflow` after the next rising edge. Changing the inputs between these two edges has no effect on that result.
- R3: When `sub` = 0 is sampled, `s` equals (a + b) modulo 2^WIDTH.
- R4: When `sub` = 1 is sampled, `s` equals (a - b) modulo 2^WIDTH.
- R5: `overflow` is 1 exactly when the true signed sum or difference lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1]. For WIDTH = 8 this covers 127 + 1, -128 - 1, -128 + -128 and 0 - (-128). `overflow` is registered together with `s`.
- R6: Driving `rst_n` low clears `s` and `overflow` to 0 at once, with no clock edge needed. It also clears the captured operands and mode.
- R7: On the first two rising edges after reset is released, `s` = 0 and `overflow` = 0 are produced, because the cleared operand stage computes 0 + 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers use the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a | input | WIDTH | First operand, two's complement |
| b | input | WIDTH | Second operand, two's complement |
| sub | input | 1 | 0 selects a + b, 1 selects a - b |
| s | output | WIDTH | Registered result |
| overflow | output | 1 | Registered signed-overflow flag |

## Verification
The checker assumes that `a`, `b` and `sub` are never unknown and that they change only between clock edges. It builds its own two-edge delay line of the inputs and computes a wide signed reference result from that line. The bench therefore drives every input on the falling edge, and it releases reset away from the rising edge. The bench pushes reset low in the middle of a cycle, so the clear without a clock is seen at the ports.

// File: rtl/sgn_addsub_pkg.sv
package sgn_addsub_pkg;

   typedef enum logic {
      OP_ADD = 1'b0,
      OP_SUB = 1'b1
   } addsub_op_e;

   // Signed overflow from the operand signs and the result sign
   function automatic logic ovf_from_signs(input logic sa, input logic sb_eff,
                                           input logic sr);
      return (sa == sb_eff) && (sr != sa);
   endfunction

endpackage

// File: rtl/sgn_addsub_fa_cell.sv
module sgn_addsub_fa_cell (
   input  logic x,
   input  logic y,
   input  logic cin,
   output logic sum,
   output logic cout
);
   logic prop;

   assign prop = x ^ y;
   assign sum  = prop ^ cin;
   assign cout = (x & y) | (cin & prop);
endmodule

// File: rtl/sgn_addsub_ripple.sv
module sgn_addsub_ripple #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             c_into_msb,
   output logic             c_out
);
   localparam int NCARRY = WIDTH + 1;

   logic [NCARRY-1:0] carry;

   assign carry[0] = cin;

   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      sgn_addsub_fa_cell u_fa (
         .x    (x[i]),
         .y    (y[i]),
         .cin  (carry[i]),
         .sum  (sum[i]),
         .cout (carry[i+1])
      );
   end

   assign c_into_msb = carry[WIDTH-1];
   assign c_out      = carry[WIDTH];
endmodule

// File: rtl/sgn_addsub_pipe_reg.sv
module sgn_addsub_pipe_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/sgn_addsub_reg.sv
module sgn_addsub_reg
   import sgn_addsub_pkg::*;
#(
   parameter int WIDTH         = 8,
   parameter bit OVF_CARRY_XOR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   output logic [WIDTH-1:0] s,
   output logic             overflow
);
   localparam int IN_W  = 2 * WIDTH + 1;
   localparam int OUT_W = WIDTH + 1;
   localparam int MSB   = WIDTH - 1;

   initial begin
      assert (WIDTH >= 2)
         else $error("sgn_addsub_reg: WIDTH must be at least 2");
   end

   // operand stage: {mode, a, b}
   logic [IN_W-1:0] in_d, in_q;
   logic [WIDTH-1:0] a_q, b_q;
   addsub_op_e       op_q;

   assign in_d = {sub, a, b};

   sgn_addsub_pipe_reg #(.WIDTH(IN_W)) u_in_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (in_d),
      .q     (in_q)
   );

   assign op_q = addsub_op_e'(in_q[IN_W-1]);
   assign a_q  = in_q[2*WIDTH-1:WIDTH];
   assign b_q  = in_q[WIDTH-1:0];

   // conditional inversion of the second operand
   logic [WIDTH-1:0] b_eff;
   logic             mode_bit;

   assign mode_bit = (op_q == OP_SUB);
   assign b_eff    = b_q ^ {WIDTH{mode_bit}};

   logic [WIDTH-1:0] sum_c;
   logic             c_msb_in, c_msb_out;

   sgn_addsub_ripple #(.WIDTH(WIDTH)) u_chain (
      .x          (a_q),
      .y          (b_eff),
      .cin        (mode_bit),
      .sum        (sum_c),
      .c_into_msb (c_msb_in),
      .c_out      (c_msb_out)
   );

   logic ovf_c;

   if (OVF_CARRY_XOR) begin : g_ovf_carry
      assign ovf_c = c_msb_in ^ c_msb_out;
   end else begin : g_ovf_sign
      assign ovf_c = ovf_from_signs(a_q[MSB], b_eff[MSB], sum_c[MSB]);
   end

   // result stage: {overflow, sum}
   logic [OUT_W-1:0] out_q;

   sgn_addsub_pipe_reg #(.WIDTH(OUT_W)) u_out_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ovf_c, sum_c}),
      .q     (out_q)
   );

   assign s        = out_q[WIDTH-1:0];
   assign overflow = out_q[WIDTH];
endmodule

// File: rtl/sgn_addsub_reg_chk.sv
module sgn_addsub_reg_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b,
   input logic             sub,
   input logic [WIDTH-1:0] s,
   input logic             overflow
);
   localparam int XW = WIDTH + 1;

   logic [WIDTH-1:0] a_d1, a_d2, b_d1, b_d2;
   logic             sub_d1, sub_d2;
   logic [1:0]       since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_d1 <= '0; a_d2 <= '0;
         b_d1 <= '0; b_d2 <= '0;
         sub_d1 <= 1'b0; sub_d2 <= 1'b0;
         since_rst <= '0;
      end else begin
         a_d1 <= a;   a_d2 <= a_d1;
         b_d1 <= b;   b_d2 <= b_d1;
         sub_d1 <= sub; sub_d2 <= sub_d1;
         if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
      end
   end

   logic signed [XW-1:0] ax, bx, wide;
   logic [WIDTH-1:0]     ref_s;
   logic                 ref_ovf, valid;

   always_comb begin
      ax      = {a_d2[WIDTH-1], a_d2};
      bx      = {b_d2[WIDTH-1], b_d2};
      wide    = sub_d2 ? (ax - bx) : (ax + bx);
      ref_s   = wide[WIDTH-1:0];
      ref_ovf = wide[XW-1] != wide[XW-2];
      valid   = since_rst >= 2'd2;
   end

   // R3
   a_r3_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !sub_d2) |-> (s == ref_s));

   // R4
   a_r4_sub_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && sub_d2) |-> (s == ref_s));

   // R5
   a_r5_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (overflow == ref_ovf));

   // R6
   a_r6_reset_clear: assert property (@(posedge clk)
      !rst_n |-> (s == '0 && !overflow));

   // R7
   a_r7_post_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst <= 2'd1) |-> (s == '0 && !overflow));
endmodule

bind sgn_addsub_reg sgn_addsub_reg_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .a        (a),
   .b        (b),
   .sub      (sub),
   .s        (s),
   .overflow (overflow)
);

// File: tb/sgn_addsub_reg_tb.sv
`timescale 1ns/1ps
module sgn_addsub_reg_tb;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a = '0, b = '0;
   logic         sub = 1'b0;
   logic [W-1:0] s;
   logic         overflow;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;   // 50 MHz

   sgn_addsub_reg #(.WIDTH(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .a(a), .b(b), .sub(sub),
      .s(s), .overflow(overflow)
   );

   // behavioural reference: queue of captured operations, integer arithmetic
   int m_a1 = 0, m_b1 = 0, m_sub1 = 0;
   int m_s = 0, m_o = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_a1 <= 0; m_b1 <= 0; m_sub1 <= 0; m_s <= 0; m_o <= 0;
      end else begin
         int r;
         r = (m_sub1 != 0) ? (m_a1 - m_b1) : (m_a1 + m_b1);
         m_s <= r & 255;
         m_o <= (r > 127 || r < -128) ? 1 : 0;
         m_a1 <= $signed(a);
         m_b1 <= $signed(b);
         m_sub1 <= sub;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // compare outputs with the model, then drive the next vector (on negedge)
   task automatic step(input int va, input int vb, input bit vsub);
      @(negedge clk);
      chk((m_sub1 == 0 && m_s == m_s) ? "R3/R5-or-R4 sum" : "sum", int'(s), m_s);
      if (overflow !== m_o[0]) begin
         n_chk++; n_bad++;
         $display("FAIL R5 overflow actual=%0d expected=%0d at %0t", overflow, m_o, $time);
      end else n_chk++;
      a = va[W-1:0]; b = vb[W-1:0]; sub = vsub;
   endtask

   // one directed operation, result read two edges later
   task automatic directed(input string req, input int va, input int vb,
                           input bit vsub, input int es, input int eo);
      step(va, vb, vsub);
      step(0, 0, 1'b0);
      step(0, 0, 1'b0);
      chk(req, int'(s), es & 255);
      chk({req, " ovf"}, int'(overflow), eo);
   endtask

   initial begin
      #100000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   int vals[9] = '{-128, -127, -1, 0, 1, 63, 64, 126, 127};

   initial begin
      // R6: outputs cleared while reset held
      #35;
      chk("R6 reset s", int'(s), 0);
      chk("R6 reset ovf", int'(overflow), 0);
      @(negedge clk); a = 8'd5; b = 8'd3; sub = 1'b0;
      rst_n = 1'b1;
      // R7: first edges after release give zero
      @(negedge clk);
      chk("R7 first edge s", int'(s), 0);
      chk("R7 first edge ovf", int'(overflow), 0);
      // R2: change inputs after capture, must not affect result
      a = 8'd100; b = 8'd100;
      @(negedge clk);
      chk("R2 latency s", int'(s), 8);
      chk("R2 latency ovf", int'(overflow), 0);
      // R5 corners, R3/R4
      directed("R5 127+1",        127,  1, 1'b0, -128, 1);
      directed("R5 -128-1",      -128,  1, 1'b1,  127, 1);
      directed("R5 -128+-128",   -128, -128, 1'b0,  0, 1);
      directed("R5 0-(-128)",       0, -128, 1'b1, -128, 1);
      directed("R4 -1-(-128)",     -1, -128, 1'b1,  127, 0);
      directed("R3 -1+1",          -1,  1, 1'b0,    0, 0);
      directed("R4 5-7",            5,  7, 1'b1,   -2, 0);
      directed("R1 signed -100+-28", -100, -28, 1'b0, -128, 0);
      // R3 R4 R5: all sign combinations, both modes, compared every cycle
      for (int i = 0; i < 9; i++)
         for (int j = 0; j < 9; j++)
            for (int m = 0; m < 2; m++)
               step(vals[i], vals[j], m[0]);
      // pseudo-random stream
      begin
         logic [15:0] lf = 16'hACE1;
         for (int k = 0; k < 3000; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(int'($signed(lf[7:0])), int'($signed(lf[15:8])), lf[3]);
         end
      end
      step(0, 0, 1'b0);
      // R6: asynchronous clear mid-cycle with nonzero outputs
      step(100, 27, 1'b0);
      step(0, 0, 1'b0);
      step(0, 0, 1'b0);
      #3;
      chk("R6 pre-reset s", int'(s), 127);
      rst_n = 1'b0;
      #1;
      chk("R6 async s", int'(s), 0);
      chk("R6 async ovf", int'(overflow), 0);
      @(negedge clk); rst_n = 1'b1;
      for (int k = 0; k < 4; k++) step(-128, 1, 1'b1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule